// File: doc/BRIEF.md
# Attribute Register Bank Slave

This block is an AHB-Lite slave that holds a parameterised number of data-width registers. A packed attribute parameter gives each register its own access rule: read-write, read-only, write-one-to-clear or read-to-clear. Each register also has a hardware-side set or status input and drives a hardware-side control output with its current value.

Address-phase control is latched only in a cycle where HREADY is high. Register writes and read-to-clear side effects take effect only in the data-phase cycle that completes. Read data comes from the latched register index. An illegal access gets a two-cycle ERROR response. A wait-count parameter inserts wait states through HREADYOUT. The bank is meant to sit behind an AHB-Lite decoder. Software uses it for control fields and event flags, and hardware sets those flags or mirrors its status into them.

Top module: `ahb_attr_regbank`

## Requirements
- R1: While reset is held and on its release, HREADYOUT is 1, HRESP is 0 (OKAY) and every register reads as zero on the control output.
- R2: A transfer is valid only when HSEL and HREADY are both 1 and HTRANS is NONSEQ (2) or SEQ (3). IDLE (0), BUSY (1) or a deselected slot gives OKAY with HREADYOUT high in the next cycle and changes no register, including on read-to-clear and read-only targets.
- R3: Address-phase control is sampled only on a clock edge where HREADY is 1. A transfer presented while HREADY is 0 is dropped and writes nothing.
- R4: A write updates its register only at the end of the data-phase cycle in which HREADYOUT is 1. During any earlier data-phase cycle the old value remains on the control output.
- R5: The register index is HADDR[AW-1:2] for 32-bit data. Read data is taken from the index latched in the address phase. HRDATA is zero outside a legal read data phase.
- R6: The attribute of register i sits at ATTRS[2i+1:2i], where 0 is read-write, 1 is read-only, 2 is write-one-to-clear and 3 is read-to-clear. A read-write register takes the written word, and hardware set bits are ORed in on top of it, including in the commit cycle.
- R7: A read-only register takes its hardware input value one cycle later. A write to it is illegal and leaves its value unchanged.
- R8: In a write-one-to-clear register, each 1 written clears that bit and each 0 leaves it alone. A hardware set of a bit in the commit cycle keeps that bit at 1.
- R9: A read-to-clear register accumulates hardware set bits. A completed legal read returns its value and clears it, except for bits set by hardware in the completing cycle, which stay set.
- R10: The following are illegal: a write to a read-only register, an index of NREGS or more, an HSIZE other than the full word (code 2 for 32-bit), or an address that is not word aligned. An illegal access gets HRESP=1 with HREADYOUT=0 in one cycle, then HRESP=1 with HREADYOUT=1 in the next, and changes no register.
- R11: With WAITS=W, a legal transfer's data phase shows HREADYOUT low with OKAY for exactly W cycles and then HREADYOUT high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hrst | input | 1 | Synchronous active-high reset |
| hsel | input | 1 | Slave select from the decoder |
| haddr | input | AW | Byte address within the bank |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size code |
| hwdata | input | DW | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready, previous transfer done |
| hreadyout | output | 1 | This slave's ready |
| hresp | output | 1 | 0 OKAY, 1 ERROR |
| hrdata | output | DW | Read data |
| hw_status | input | NREGS*DW | Per-register hardware set or status value, register i at bits [i*DW +: DW] |
| ctrl_out | output | NREGS*DW | Current value of every register, same packing |

## Verification
A software clear and a hardware set can land on the same register in the same commit cycle. Software can write 1s into a write-one-to-clear register, or complete a read of a read-to-clear register, while hardware raises a bit in that register. The bench provokes this by holding a hardware set pulse on the target bit through the whole data phase of that write or read, wait cycle and commit cycle included. It judges the result from the control output after completion: the pulsed bit must remain set and the other cleared bits must be zero. For the read case, the returned data must already include the bit that was set during the wait cycle.

// File: rtl/attr_regbank_pkg.sv
package attr_regbank_pkg;

  // Per-register access rule, two bits each in the ATTRS parameter
  typedef enum logic [1:0] {
    ATTR_RW  = 2'd0,
    ATTR_RO  = 2'd1,
    ATTR_W1C = 2'd2,
    ATTR_RC  = 2'd3
  } attr_e;

  localparam logic [1:0] TR_IDLE   = 2'd0;
  localparam logic [1:0] TR_BUSY   = 2'd1;
  localparam logic [1:0] TR_NONSEQ = 2'd2;
  localparam logic [1:0] TR_SEQ    = 2'd3;

  // Response sequencer states
  typedef enum logic [1:0] {
    RS_IDLE,
    RS_WAIT,
    RS_ERR1,
    RS_ERR2
  } rsp_state_e;

endpackage

// File: rtl/ahb_addr_latch.sv
// Address-phase capture: legality is decided here, control is held
// across wait cycles because the register only loads while hready is high.
module ahb_addr_latch
  import attr_regbank_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREGS = 8,
  parameter int AW    = 6,
  parameter logic [2*NREGS-1:0] ATTRS = '0,
  localparam int BSH  = $clog2(DW/8),
  localparam int IW   = AW - BSH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hsel,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [2:0]    hsize,
  input  logic [AW-1:0] haddr,
  input  logic          hready,
  output logic          accept,
  output logic          accept_err,
  output logic          sel_q,
  output logic          write_q,
  output logic          err_q,
  output logic [IW-1:0] idx_q
);

  localparam logic [2:0] SZ_WORD = 3'(BSH);

  logic [IW-1:0]    idx;
  logic [NREGS-1:0] ro_mask;
  logic             ro_hit;
  logic             out_rng;
  logic             illegal;

  assign idx = haddr[AW-1:BSH];

  for (genvar g = 0; g < NREGS; g++) begin : g_ro
    assign ro_mask[g] = (ATTRS[2*g +: 2] == ATTR_RO);
  end

  always_comb begin
    ro_hit = 1'b0;
    for (int i = 0; i < NREGS; i++) begin
      if (idx == IW'(i)) ro_hit = ro_mask[i];
    end
  end

  assign out_rng = ({1'b0, idx} >= (IW+1)'(NREGS));
  assign illegal = out_rng
                 | (hsize != SZ_WORD)
                 | (haddr[BSH-1:0] != '0)
                 | (hwrite & ro_hit);

  assign accept     = hsel & hready & ((htrans == TR_NONSEQ) | (htrans == TR_SEQ));
  assign accept_err = accept & illegal;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      write_q <= 1'b0;
      err_q   <= 1'b0;
      idx_q   <= '0;
    end else if (hready) begin
      sel_q   <= accept;
      write_q <= hwrite;
      err_q   <= accept_err;
      idx_q   <= idx;
    end
  end

endmodule

// File: rtl/ahb_resp_seq.sv
// Registered HREADYOUT / HRESP: wait counter and two-cycle error.
module ahb_resp_seq
  import attr_regbank_pkg::*;
#(
  parameter int WAITS = 0,
  localparam int CW   = (WAITS > 0) ? $clog2(WAITS + 1) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic accept_err,
  output logic hreadyout,
  output logic hresp
);

  rsp_state_e     st;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RS_IDLE;
      cnt       <= '0;
      hreadyout <= 1'b1;
      hresp     <= 1'b0;
    end else begin
      case (st)
        RS_WAIT: begin
          if (cnt <= CW'(1)) begin
            st        <= RS_IDLE;
            cnt       <= '0;
            hreadyout <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        RS_ERR1: begin
          st        <= RS_ERR2;
          hreadyout <= 1'b1;
          hresp     <= 1'b1;
        end
        default: begin
          // RS_IDLE and RS_ERR2 both end a data phase with hreadyout high
          if (accept_err) begin
            st        <= RS_ERR1;
            hreadyout <= 1'b0;
            hresp     <= 1'b1;
          end else if (accept && (WAITS > 0)) begin
            st        <= RS_WAIT;
            cnt       <= CW'(WAITS);
            hreadyout <= 1'b0;
            hresp     <= 1'b0;
          end else begin
            st        <= RS_IDLE;
            hreadyout <= 1'b1;
            hresp     <= 1'b0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/attr_reg_file.sv
// Register array: one generated register per index, rule picked by ATTRS.
module attr_reg_file
  import attr_regbank_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREGS = 8,
  parameter int IW    = 4,
  parameter logic [2*NREGS-1:0] ATTRS = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                commit,
  input  logic                rd_en,
  input  logic                write_q,
  input  logic [IW-1:0]       idx_q,
  input  logic [DW-1:0]       wdata,
  input  logic [NREGS*DW-1:0] hw_in,
  output logic [NREGS*DW-1:0] q,
  output logic [DW-1:0]       rdata
);

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam attr_e A = attr_e'(ATTRS[2*g +: 2]);
    logic [DW-1:0] r;
    logic [DW-1:0] base;

    if (A == ATTR_RW) begin : g_rw
      logic hit;
      assign hit  = commit & write_q & (idx_q == IW'(g));
      assign base = hit ? wdata : r;
    end else if (A == ATTR_RO) begin : g_ro
      assign base = '0;
    end else if (A == ATTR_W1C) begin : g_w1c
      logic hit;
      assign hit  = commit & write_q & (idx_q == IW'(g));
      assign base = hit ? (r & ~wdata) : r;
    end else begin : g_rc
      logic hit;
      assign hit  = commit & ~write_q & (idx_q == IW'(g));
      assign base = hit ? '0 : r;
    end

    // hardware set bits always land on top of the software result
    always_ff @(posedge clk) begin
      if (rst) r <= '0;
      else     r <= base | hw_in[g*DW +: DW];
    end

    assign q[g*DW +: DW] = r;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int i = 0; i < NREGS; i++) begin
        if (idx_q == IW'(i)) rdata = q[i*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/ahb_attr_regbank.sv
module ahb_attr_regbank
  import attr_regbank_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREGS = 8,
  parameter int AW    = 6,
  parameter int WAITS = 0,
  parameter logic [2*NREGS-1:0] ATTRS = 16'hE4E4,
  localparam int BSH  = $clog2(DW/8),
  localparam int IW   = AW - BSH
) (
  input  logic                hclk,
  input  logic                hrst,
  input  logic                hsel,
  input  logic [AW-1:0]       haddr,
  input  logic [1:0]          htrans,
  input  logic                hwrite,
  input  logic [2:0]          hsize,
  input  logic [DW-1:0]       hwdata,
  input  logic                hready,
  output logic                hreadyout,
  output logic                hresp,
  output logic [DW-1:0]       hrdata,
  input  logic [NREGS*DW-1:0] hw_status,
  output logic [NREGS*DW-1:0] ctrl_out
);

  logic          accept, accept_err;
  logic          sel_q, write_q, err_q;
  logic [IW-1:0] idx_q;
  logic          commit, rd_en;

  ahb_addr_latch #(
    .DW(DW), .NREGS(NREGS), .AW(AW), .ATTRS(ATTRS)
  ) u_cap (
    .clk(hclk), .rst(hrst),
    .hsel(hsel), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .haddr(haddr), .hready(hready),
    .accept(accept), .accept_err(accept_err),
    .sel_q(sel_q), .write_q(write_q), .err_q(err_q), .idx_q(idx_q)
  );

  ahb_resp_seq #(.WAITS(WAITS)) u_rsp (
    .clk(hclk), .rst(hrst),
    .accept(accept), .accept_err(accept_err),
    .hreadyout(hreadyout), .hresp(hresp)
  );

  // side effects only in the completing data-phase cycle
  assign commit = sel_q & ~err_q & hreadyout;
  assign rd_en  = sel_q & ~err_q & ~write_q;

  attr_reg_file #(
    .DW(DW), .NREGS(NREGS), .IW(IW), .ATTRS(ATTRS)
  ) u_regs (
    .clk(hclk), .rst(hrst),
    .commit(commit), .rd_en(rd_en), .write_q(write_q), .idx_q(idx_q),
    .wdata(hwdata), .hw_in(hw_status),
    .q(ctrl_out), .rdata(hrdata)
  );

endmodule

// File: rtl/attr_regbank_chk.sv
module attr_regbank_chk #(
  parameter int DW    = 32,
  parameter int IW    = 4,
  parameter int WAITS = 0
) (
  input logic          clk,
  input logic          rst,
  input logic          hready,
  input logic          hreadyout,
  input logic          hresp,
  input logic          accept,
  input logic          accept_err,
  input logic          sel_q,
  input logic          write_q,
  input logic          err_q,
  input logic [IW-1:0] idx_q,
  input logic [DW-1:0] hrdata
);

  // R10
  err_second_chk: assert property (@(posedge clk) disable iff (rst)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

  // R10
  err_first_chk: assert property (@(posedge clk) disable iff (rst)
    (hresp && hreadyout) |-> $past(hresp && !hreadyout));

  // R10
  err_owner_chk: assert property (@(posedge clk) disable iff (rst)
    hresp |-> (sel_q && err_q));

  // R2
  idle_okay_chk: assert property (@(posedge clk) disable iff (rst)
    (hready && !accept) |=> (hreadyout && !hresp));

  // R3
  hold_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !hready |=> $stable({sel_q, write_q, err_q, idx_q}));

  // R5
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_q || write_q || err_q) |-> (hrdata == '0));

  // R11
  if (WAITS > 0) begin : g_wait_chk
    wait_low_chk: assert property (@(posedge clk) disable iff (rst)
      (accept && !accept_err) |=> (!hreadyout && !hresp));
  end

endmodule

bind ahb_attr_regbank attr_regbank_chk #(
  .DW(DW), .IW(IW), .WAITS(WAITS)
) u_chk (
  .clk(hclk), .rst(hrst), .hready(hready), .hreadyout(hreadyout),
  .hresp(hresp), .accept(accept), .accept_err(accept_err),
  .sel_q(sel_q), .write_q(write_q), .err_q(err_q), .idx_q(idx_q),
  .hrdata(hrdata)
);

// File: tb/tb_ahb_attr_regbank.sv
`timescale 1ns/1ps
module tb_ahb_attr_regbank;

  localparam int TB_WAITS = 1;

  logic         clk = 1'b0;
  logic         rst;
  logic         hsel, hwrite, stall;
  logic [1:0]   htrans;
  logic [2:0]   hsize;
  logic [5:0]   haddr;
  logic [31:0]  hwdata;
  logic [255:0] hw_base, hw_pulse, hw_status;
  logic         hready, hreadyout, hresp;
  logic [31:0]  hrdata;
  logic [255:0] ctrl_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // results of the last transfer
  logic         r_first_resp, r_first_rdy, r_resp;
  logic [31:0]  r_rdata;
  logic [255:0] r_early;
  int           r_nw;

  // table fields
  logic         v_wr, v_err;
  logic [3:0]   v_idx;
  logic [31:0]  v_wd, v_rd;

  always #4 clk = ~clk;

  assign hready    = hreadyout & ~stall;
  assign hw_status = hw_base | hw_pulse;

  ahb_attr_regbank #(.WAITS(TB_WAITS)) dut (
    .hclk(clk), .hrst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
    .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
    .hw_status(hw_status), .ctrl_out(ctrl_out)
  );

  // {write, index, wdata, expect error, expect rdata}; registers 0..7 are
  // RW, RO, W1C, RC, RW, RO, W1C, RC; hardware inputs held at zero
  localparam logic [69:0] VEC [10] = '{
    {1'b1, 4'd0,  32'hA5A5_1234, 1'b0, 32'h0},
    {1'b0, 4'd0,  32'h0,         1'b0, 32'hA5A5_1234},
    {1'b1, 4'd4,  32'h0000_FFFF, 1'b0, 32'h0},
    {1'b0, 4'd4,  32'h0,         1'b0, 32'h0000_FFFF},
    {1'b0, 4'd0,  32'h0,         1'b0, 32'hA5A5_1234},
    {1'b1, 4'd1,  32'h0000_1234, 1'b1, 32'h0},
    {1'b0, 4'd1,  32'h0,         1'b0, 32'h0},
    {1'b1, 4'd9,  32'h1111_1111, 1'b1, 32'h0},
    {1'b0, 4'd12, 32'h0,         1'b1, 32'h0},
    {1'b0, 4'd2,  32'h0,         1'b0, 32'h0}
  };

  function automatic logic [31:0] regv(input int i);
    return ctrl_out[i*32 +: 32];
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    hsel = 1'b0; htrans = 2'd0; hwrite = 1'b0; haddr = '0; hsize = 3'd2;
  endtask

  task automatic xfer(input logic wr, input logic [5:0] addr,
                      input logic [2:0] sz, input logic [31:0] wd,
                      input logic [255:0] pulse);
    bit first;
    @(negedge clk);
    hsel = 1'b1; htrans = 2'd2; hwrite = wr; haddr = addr; hsize = sz;
    @(posedge clk);
    #1;
    bus_idle();
    hwdata   = wd;
    hw_pulse = pulse;
    r_nw  = 0;
    first = 1'b1;
    forever begin
      @(negedge clk);
      if (first) begin
        r_first_resp = hresp;
        r_first_rdy  = hreadyout;
        r_early      = ctrl_out;
        first        = 1'b0;
      end
      if (hreadyout) begin
        r_resp  = hresp;
        r_rdata = hrdata;
        break;
      end
      r_nw++;
    end
    @(posedge clk);
    #1;
    hw_pulse = '0;
    hwdata   = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired before the run ended");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; stall = 1'b0;
    hw_base = '0; hw_pulse = '0; hwdata = '0;
    bus_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(hreadyout == 1'b1, "R1 hreadyout in reset", 32'(hreadyout), 32'd1);
    chk(hresp == 1'b0,     "R1 hresp in reset",     32'(hresp),     32'd0);
    chk(ctrl_out == '0,    "R1 registers zero",     ctrl_out[31:0], 32'd0);
    rst = 1'b0;

    // table walk: R5 R6 R7 R10 R11
    for (int i = 0; i < 10; i++) begin
      {v_wr, v_idx, v_wd, v_err, v_rd} = VEC[i];
      xfer(v_wr, {v_idx, 2'b00}, 3'd2, v_wd, '0);
      if (v_err) begin
        chk(r_first_resp && !r_first_rdy, "R10 error first cycle",
            {30'd0, r_first_resp, r_first_rdy}, 32'd2);
        chk(r_resp && r_nw == 1, "R10 error second cycle",
            32'(r_resp), 32'd1);
      end else begin
        chk(!r_resp && r_nw == TB_WAITS, "R11 wait count and OKAY",
            32'(r_nw), 32'(TB_WAITS));
        if (!v_wr)
          chk(r_rdata == v_rd, "R5 read data from latched index", r_rdata, v_rd);
      end
    end
    chk(regv(1) == 32'h0, "R7 rejected write left register", regv(1), 32'h0);

    // R4 commit only in completing cycle; R6 hardware set on RW register
    xfer(1'b1, 6'd16, 3'd2, 32'h0000_1100, 256'(1) << 128);
    chk(r_early[128 +: 32] == 32'h0000_FFFF, "R4 no commit during wait cycle",
        r_early[128 +: 32], 32'h0000_FFFF);
    chk(regv(4) == 32'h0000_1101, "R6 write value with hardware set ORed",
        regv(4), 32'h0000_1101);

    // R3 transfer offered while hready low is dropped
    @(negedge clk);
    hsel = 1'b1; htrans = 2'd2; hwrite = 1'b1; haddr = 6'd0; stall = 1'b1;
    @(negedge clk);
    bus_idle(); stall = 1'b0; hwdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk(regv(0) == 32'hA5A5_1234, "R3 stalled write dropped", regv(0), 32'hA5A5_1234);
    chk(hreadyout && !hresp, "R3 no response to dropped transfer",
        {30'd0, hreadyout, hresp}, 32'd2);
    hwdata = '0;

    // R7 read-only mirrors hardware, write rejected
    hw_base[32 +: 32] = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    xfer(1'b0, 6'd4, 3'd2, '0, '0);
    chk(r_rdata == 32'hDEAD_BEEF, "R7 read-only mirror", r_rdata, 32'hDEAD_BEEF);
    xfer(1'b1, 6'd4, 3'd2, 32'h0, '0);
    chk(r_first_resp && r_resp, "R7 write to read-only errors", 32'(r_resp), 32'd1);
    chk(regv(1) == 32'hDEAD_BEEF, "R7 value kept after rejected write",
        regv(1), 32'hDEAD_BEEF);
    hw_base = '0;

    // R8 write-one-to-clear
    @(negedge clk); hw_pulse[64 +: 32] = 32'h0000_00F0;
    @(negedge clk); hw_pulse = '0;
    @(negedge clk);
    chk(regv(2) == 32'h0000_00F0, "R8 hardware set captured", regv(2), 32'h0000_00F0);
    xfer(1'b1, 6'd8, 3'd2, 32'h0000_0030, '0);
    chk(regv(2) == 32'h0000_00C0, "R8 ones clear, zeros keep", regv(2), 32'h0000_00C0);
    xfer(1'b1, 6'd8, 3'd2, 32'h0000_00C0, 256'h40 << 64);
    chk(regv(2) == 32'h0000_0040, "R8 same-cycle set beats clear", regv(2), 32'h0000_0040);

    // R9 read-to-clear
    @(negedge clk); hw_pulse[96 +: 32] = 32'h5;
    @(negedge clk); hw_pulse = '0;
    @(negedge clk);
    chk(regv(3) == 32'h5, "R9 hardware set accumulates", regv(3), 32'h5);
    xfer(1'b0, 6'd12, 3'd2, '0, '0);
    chk(r_rdata == 32'h5, "R9 read returns value", r_rdata, 32'h5);
    chk(regv(3) == 32'h0, "R9 completed read clears", regv(3), 32'h0);
    xfer(1'b0, 6'd12, 3'd2, '0, 256'h8 << 96);
    chk(r_rdata == 32'h8, "R9 read sees wait-cycle set", r_rdata, 32'h8);
    chk(regv(3) == 32'h8, "R9 same-cycle set survives clear", regv(3), 32'h8);

    // R2 IDLE slot on the read-to-clear register
    @(negedge clk);
    hsel = 1'b1; htrans = 2'd0; hwrite = 1'b0; haddr = 6'd12;
    @(negedge clk);
    bus_idle();
    chk(hreadyout && !hresp, "R2 IDLE gets OKAY with no wait",
        {30'd0, hreadyout, hresp}, 32'd2);
    @(negedge clk);
    chk(regv(3) == 32'h8, "R2 IDLE does not clear", regv(3), 32'h8);
    // R2 BUSY write to the read-only register
    hsel = 1'b1; htrans = 2'd1; hwrite = 1'b1; haddr = 6'd4;
    @(negedge clk);
    bus_idle();
    chk(hreadyout && !hresp, "R2 BUSY gets no error",
        {30'd0, hreadyout, hresp}, 32'd2);
    xfer(1'b0, 6'd12, 3'd2, '0, '0);
    chk(r_rdata == 32'h8 && regv(3) == 32'h0, "R9 later read clears",
        regv(3), 32'h0);

    // R10 size and alignment
    xfer(1'b0, 6'd0, 3'd1, '0, '0);
    chk(r_first_resp && !r_first_rdy && r_resp, "R10 halfword size errors",
        32'(r_resp), 32'd1);
    chk(r_rdata == 32'h0, "R5 no read data on error", r_rdata, 32'h0);
    xfer(1'b0, 6'd1, 3'd2, '0, '0);
    chk(r_first_resp && r_resp, "R10 misaligned address errors", 32'(r_resp), 32'd1);
    xfer(1'b1, 6'd0, 3'd1, 32'h0, '0);
    chk(regv(0) == 32'hA5A5_1234, "R10 errored write leaves register",
        regv(0), 32'hA5A5_1234);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule